// File: doc/BRIEF.md
# IDE Channel Legacy/Native Address Decoder

This block is the configuration-space side of a two-channel PCI IDE function. It keeps the command register's I/O-enable bit, four I/O base address registers and the 32-bit timing word at configuration offset 40h. From these it works out which channel, and which register block of that channel, an I/O access hits. It also routes each channel's interrupt request either to its fixed legacy IRQ line or to the shared PCI interrupt.

The mode of each channel comes from one bit in that channel's timing register. When the bit is set, the channel answers at the fixed compatibility addresses. When it is clear, the channel answers through its base registers.

The BARs are steered when the primary channel is legacy and the secondary is native. In that case the secondary channel uses the first BAR pair, so software programs BAR0/BAR1 for it.

The configuration port and the I/O probe are single-cycle control interfaces. Every access completes in the cycle it is presented, so they carry no valid/ready handshake and cannot apply back-pressure. Register writes take effect at the next rising clock edge. Configuration read data, I/O hit signals and I/O read data are combinational. The interrupt outputs are registered, which gives one cycle of latency.

Top module: `ide_mode_decoder`

## Requirements
- R1: Bit 7 of byte 41h (bit 15 of the dword at 40h) sets the primary channel to legacy when 1 and native when 0. Bit 7 of byte 43h (bit 31 of that dword, bit 15 of the word at 42h) does the same for the secondary channel. Both bits reset to 0, and each channel's mode is independent of the other.
- R2: A configuration write changes only the bytes whose byte enable is set. Bytes 40h–43h read back exactly what was written.
- R3: BAR0 and BAR2 (dwords 10h, 18h) are command-block bases with 8-byte alignment. Bits 2:0 read 001, bits 15:3 are writable, and bits 31:16 read 0. BAR1 and BAR3 (14h, 1Ch) are control-block bases with 4-byte alignment: bits 1:0 read 01. All BARs reset to a base of 0. Unimplemented dwords read 0.
- R4: A legacy primary channel hits its command block at 1F0h–1F7h and its control block at 3F6h. A legacy secondary channel hits 170h–177h and 376h. The BARs play no part in legacy decode.
- R5: With both channels native, the primary decodes its 8-byte command block at BAR0 and its 4-byte control block at BAR1. The secondary uses BAR2 and BAR3.
- R6: With the primary legacy and the secondary native, the secondary decodes through BAR0/BAR1, and the BAR2/BAR3 ranges do not respond.
- R7: Bit 0 of the command register (dword 04h) enables I/O decode and resets to 0. While it is 0, no hit signal asserts in any mode. Only bit 0 reads back.
- R8: An I/O access that hits no enabled range returns FFh on io_rdata. A hit returns the data of the channel that was hit.
- R9: irq14 follows the primary request and irq15 follows the secondary request while that channel is legacy, one cycle later, whatever the value of the command enable. A native channel holds its legacy line low.
- R10: pci_int is, one cycle later, the OR of the requests of the native channels, and it is forced low while the command enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw | input | 6 | Configuration dword index (byte offset / 4) |
| cfg_be | input | 4 | Configuration byte enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_dw |
| io_strobe | input | 1 | I/O access present |
| io_addr | input | 16 | I/O address |
| pri_rdata | input | 8 | Read data from the primary task file |
| sec_rdata | input | 8 | Read data from the secondary task file |
| io_rdata | output | 8 | I/O read data (FFh on miss) |
| pri_cmd_hit | output | 1 | Primary command-block hit |
| pri_ctl_hit | output | 1 | Primary control-block hit |
| sec_cmd_hit | output | 1 | Secondary command-block hit |
| sec_ctl_hit | output | 1 | Secondary control-block hit |
| pri_irq_req | input | 1 | Primary channel interrupt request |
| sec_irq_req | input | 1 | Secondary channel interrupt request |
| irq14 | output | 1 | Legacy primary interrupt |
| irq15 | output | 1 | Legacy secondary interrupt |
| pci_int | output | 1 | Shared PCI interrupt |

## Verification
A wrong mode bit or a lost byte-enable merge shows up at once on the next I/O probe. The channel answers at compatibility addresses instead of BAR addresses, or the reverse, and the timing dword reads back wrong in the same cycle. Broken BAR steering shows as the secondary channel answering at BAR2 or missing at BAR0 whenever the primary is legacy. An interrupt routed to the wrong line, or not gated by the enable, appears on irq14/irq15/pci_int exactly one clock after the request or mode change.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
  localparam int IO_AW    = 16;
  localparam int NCH      = 2;
  localparam int NBAR     = 2 * NCH;
  localparam int CMD_LG   = 3;   // command block spans 8 bytes
  localparam int CTL_LG   = 2;   // control block spans 4 bytes
  localparam int MODE_BIT = 7;   // legacy-select bit inside each timing high byte
  localparam logic [5:0] DW_CMD  = 6'h01;
  localparam logic [5:0] DW_BAR0 = 6'h04;
  localparam logic [5:0] DW_TIM  = 6'h10;

  function automatic logic [IO_AW-1:0] leg_cmd_base(input int ch);
    return (ch == 0) ? 16'h01F0 : 16'h0170;
  endfunction

  function automatic logic [IO_AW-1:0] leg_ctl_addr(input int ch);
    return (ch == 0) ? 16'h03F6 : 16'h0376;
  endfunction

  function automatic logic [IO_AW-1:0] span_mask(input int lg);
    return {IO_AW{1'b1}} << lg;
  endfunction
endpackage

// File: rtl/ide_cfg_space.sv
module ide_cfg_space
  import ide_dec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [5:0]           cfg_dw,
  input  logic [3:0]           cfg_be,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  output logic                 io_en,
  output logic [NCH-1:0]       legacy,
  output logic [IO_AW-1:0]     bar_base [NBAR]
);
  localparam int BAR_BYTES = IO_AW / 8;

  logic [31:0]      tim_q;
  logic [IO_AW-1:0] bar_q  [NBAR];
  logic [IO_AW-1:0] bar_wr [NBAR];

  genvar gi;
  generate
    for (gi = 0; gi < NBAR; gi++) begin : g_bar
      localparam logic [IO_AW-1:0] MASK = span_mask((gi % 2 == 0) ? CMD_LG : CTL_LG);
      always_comb begin
        bar_wr[gi] = bar_q[gi];
        for (int b = 0; b < BAR_BYTES; b++)
          if (cfg_be[b]) bar_wr[gi][8*b +: 8] = cfg_wdata[8*b +: 8];
        bar_wr[gi] = bar_wr[gi] & MASK;
      end
      assign bar_base[gi] = bar_q[gi];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_en <= 1'b0;
      tim_q <= '0;
      for (int i = 0; i < NBAR; i++) bar_q[i] <= '0;
    end else if (cfg_wr) begin
      if (cfg_dw == DW_CMD && cfg_be[0]) io_en <= cfg_wdata[0];
      if (cfg_dw == DW_TIM)
        for (int b = 0; b < 4; b++)
          if (cfg_be[b]) tim_q[8*b +: 8] <= cfg_wdata[8*b +: 8];
      for (int i = 0; i < NBAR; i++)
        if (cfg_dw == DW_BAR0 + 6'(i)) bar_q[i] <= bar_wr[i];
    end
  end

  assign legacy[0] = tim_q[8 + MODE_BIT];
  assign legacy[1] = tim_q[24 + MODE_BIT];

  always_comb begin
    cfg_rdata = '0;
    if (cfg_dw == DW_CMD) cfg_rdata[0] = io_en;
    if (cfg_dw == DW_TIM) cfg_rdata = tim_q;
    for (int i = 0; i < NBAR; i++)
      if (cfg_dw == DW_BAR0 + 6'(i))
        cfg_rdata[IO_AW-1:0] = bar_q[i] | {{(IO_AW-1){1'b0}}, 1'b1};
  end

  // R1: a write to byte 41h lands in the primary mode bit on the next cycle
  a_r1_pri_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_dw == DW_TIM && cfg_be[1]) |=> (legacy[0] == $past(cfg_wdata[8 + MODE_BIT])));

  // R7: clearing command bit 0 turns decode off
  a_r7_cmd_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_dw == DW_CMD && cfg_be[0] && !cfg_wdata[0]) |=> !io_en);
endmodule

// File: rtl/ide_chan_decode.sv
module ide_chan_decode
  import ide_dec_pkg::*;
#(
  parameter int CH = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             legacy,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [IO_AW-1:0] cmd_base,
  input  logic [IO_AW-1:0] ctl_base,
  output logic             cmd_hit,
  output logic             ctl_hit
);
  localparam logic [IO_AW-1:0] CMD_MASK = span_mask(CMD_LG);
  localparam logic [IO_AW-1:0] CTL_MASK = span_mask(CTL_LG);
  localparam logic [IO_AW-1:0] LEG_CMD  = leg_cmd_base(CH);
  localparam logic [IO_AW-1:0] LEG_CTL  = leg_ctl_addr(CH);

  logic leg_cmd, leg_ctl, nat_cmd, nat_ctl;

  assign leg_cmd = (io_addr & CMD_MASK) == LEG_CMD;
  assign leg_ctl = io_addr == LEG_CTL;
  assign nat_cmd = (io_addr & CMD_MASK) == (cmd_base & CMD_MASK);
  assign nat_ctl = (io_addr & CTL_MASK) == (ctl_base & CTL_MASK);

  assign cmd_hit = active && (legacy ? leg_cmd : nat_cmd);
  assign ctl_hit = active && (legacy ? leg_ctl : nat_ctl);

  // R4: a legacy channel always answers its fixed control port
  a_r4_legacy_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    (active && legacy && io_addr == LEG_CTL) |-> ctl_hit);
endmodule

// File: rtl/ide_irq_route.sv
module ide_irq_route
  import ide_dec_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           io_en,
  input  logic [NCH-1:0] legacy,
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] irq_leg,
  output logic           pci_int
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_leg <= '0;
      pci_int <= 1'b0;
    end else begin
      irq_leg <= legacy & req;
      pci_int <= io_en && |(~legacy & req);
    end
  end

  // R10: PCI interrupt held low while the function is disabled
  a_r10_pci_off: assert property (@(posedge clk) disable iff (!rst_n)
    !io_en |=> !pci_int);

  // R9: a legacy request reaches its line regardless of the enable
  a_r9_leg_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy[0] && req[0]) |=> irq_leg[0]);
endmodule

// File: rtl/ide_mode_decoder.sv
module ide_mode_decoder
  import ide_dec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [5:0]  cfg_dw,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        io_strobe,
  input  logic [15:0] io_addr,
  input  logic [7:0]  pri_rdata,
  input  logic [7:0]  sec_rdata,
  output logic [7:0]  io_rdata,
  output logic        pri_cmd_hit,
  output logic        pri_ctl_hit,
  output logic        sec_cmd_hit,
  output logic        sec_ctl_hit,
  input  logic        pri_irq_req,
  input  logic        sec_irq_req,
  output logic        irq14,
  output logic        irq15,
  output logic        pci_int
);
  logic             io_en;
  logic [NCH-1:0]   legacy;
  logic [IO_AW-1:0] bar_base [NBAR];
  logic [NCH-1:0]   cmd_hit, ctl_hit, irq_leg;

  ide_cfg_space u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_en(io_en), .legacy(legacy),
    .bar_base(bar_base)
  );

  genvar ch;
  generate
    for (ch = 0; ch < NCH; ch++) begin : g_ch
      logic [IO_AW-1:0] cmd_b, ctl_b;
      if (ch == 0) begin : g_pri
        assign cmd_b = bar_base[0];
        assign ctl_b = bar_base[1];
      end else begin : g_sec
        // native secondary borrows the first BAR pair when the primary is legacy
        assign cmd_b = legacy[0] ? bar_base[0] : bar_base[2*ch];
        assign ctl_b = legacy[0] ? bar_base[1] : bar_base[2*ch+1];
      end
      ide_chan_decode #(.CH(ch)) u_dec (
        .clk(clk), .rst_n(rst_n), .active(io_strobe && io_en), .legacy(legacy[ch]),
        .io_addr(io_addr), .cmd_base(cmd_b), .ctl_base(ctl_b),
        .cmd_hit(cmd_hit[ch]), .ctl_hit(ctl_hit[ch])
      );
    end
  endgenerate

  assign pri_cmd_hit = cmd_hit[0];
  assign pri_ctl_hit = ctl_hit[0];
  assign sec_cmd_hit = cmd_hit[1];
  assign sec_ctl_hit = ctl_hit[1];

  always_comb begin
    if (cmd_hit[0] || ctl_hit[0])      io_rdata = pri_rdata;
    else if (cmd_hit[1] || ctl_hit[1]) io_rdata = sec_rdata;
    else                               io_rdata = 8'hFF;
  end

  ide_irq_route u_irq (
    .clk(clk), .rst_n(rst_n), .io_en(io_en), .legacy(legacy),
    .req({sec_irq_req, pri_irq_req}), .irq_leg(irq_leg), .pci_int(pci_int)
  );
  assign irq14 = irq_leg[0];
  assign irq15 = irq_leg[1];

  // R7: disabled function produces no hit
  a_r7_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !io_en |-> (cmd_hit == '0 && ctl_hit == '0));

  // R8: a probe that misses every range floats high
  a_r8_miss_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (io_strobe && cmd_hit == '0 && ctl_hit == '0) |-> io_rdata == 8'hFF);
endmodule

// File: tb/ide_mode_decoder_test.sv
module ide_mode_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_dw = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        io_strobe = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  pri_rdata = 8'hA5;
  logic [7:0]  sec_rdata = 8'h5A;
  logic [7:0]  io_rdata;
  logic        pri_cmd_hit, pri_ctl_hit, sec_cmd_hit, sec_ctl_hit;
  logic        pri_irq_req = 1'b0;
  logic        sec_irq_req = 1'b0;
  logic        irq14, irq15, pci_int;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  ide_mode_decoder uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_dw = dw; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic cfg_check(input string tag, input logic [5:0] dw, input logic [31:0] exp);
    @(negedge clk);
    cfg_dw = dw;
    #1 check(tag, cfg_rdata, exp);
  endtask

  // expected hits as {pri_cmd, pri_ctl, sec_cmd, sec_ctl}
  task automatic probe(input string tag, input logic [15:0] a, input logic [3:0] hits, input logic [7:0] rd);
    @(negedge clk);
    io_addr = a; io_strobe = 1'b1;
    #1;
    check(tag, {28'd0, pri_cmd_hit, pri_ctl_hit, sec_cmd_hit, sec_ctl_hit}, {28'd0, hits});
    check(tag, {24'd0, io_rdata}, {24'd0, rd});
    io_strobe = 1'b0;
  endtask

  task automatic irq_check(input string tag, input logic pr, input logic sr, input logic [2:0] exp);
    @(negedge clk);
    pri_irq_req = pr; sec_irq_req = sr;
    @(negedge clk);
    #1 check(tag, {29'd0, irq14, irq15, pci_int}, {29'd0, exp});
  endtask

  task automatic t_reset;
    check("R7 reset cmd", {31'd0, 1'b0}, 32'd0);
    cfg_check("R7 cmd reads 0", 6'h01, 32'h0);
    cfg_check("R3 BAR0 reset", 6'h04, 32'h1);
    cfg_check("R1 timing reset", 6'h10, 32'h0);
    cfg_check("R3 unimplemented dword", 6'h02, 32'h0);
    probe("R7 R8 reset no hit", 16'h0000, 4'b0000, 8'hFF);
    check("R9 R10 irq reset", {29'd0, irq14, irq15, pci_int}, 32'd0);
  endtask

  task automatic t_bars;
    cfg_write(6'h04, 4'hF, 32'hFFFF_FFFF);
    cfg_check("R3 BAR0 mask", 6'h04, 32'h0000_FFF9);
    cfg_write(6'h05, 4'hF, 32'hFFFF_FFFF);
    cfg_check("R3 BAR1 mask", 6'h05, 32'h0000_FFFD);
    cfg_write(6'h04, 4'hF, 32'h0000_C000);
    cfg_write(6'h05, 4'hF, 32'h0000_C010);
    cfg_write(6'h06, 4'hF, 32'h0000_C020);
    cfg_write(6'h07, 4'hF, 32'h0000_C030);
    cfg_check("R3 BAR2 readback", 6'h06, 32'h0000_C021);
    cfg_check("R3 BAR3 readback", 6'h07, 32'h0000_C031);
  endtask

  task automatic t_byte_enables;
    cfg_write(6'h10, 4'b0010, 32'h0000_8000);
    cfg_write(6'h10, 4'b1100, 32'h8000_0000);
    cfg_check("R1 R2 word writes", 6'h10, 32'h8000_8000);
    cfg_write(6'h10, 4'b0001, 32'hFFFF_FFFF);
    cfg_check("R2 single byte", 6'h10, 32'h8000_80FF);
    cfg_write(6'h01, 4'b0001, 32'hFFFF_FFFF);
    cfg_check("R7 cmd only bit0", 6'h01, 32'h1);
  endtask

  task automatic t_legacy;  // both legacy, enabled
    probe("R4 pri cmd lo", 16'h01F0, 4'b1000, 8'hA5);
    probe("R4 pri cmd hi", 16'h01F7, 4'b1000, 8'hA5);
    probe("R4 pri past end", 16'h01F8, 4'b0000, 8'hFF);
    probe("R4 pri ctl", 16'h03F6, 4'b0100, 8'hA5);
    probe("R4 pri ctl neighbour", 16'h03F7, 4'b0000, 8'hFF);
    probe("R4 sec cmd", 16'h0174, 4'b0010, 8'h5A);
    probe("R4 sec ctl", 16'h0376, 4'b0001, 8'h5A);
    probe("R4 BAR ignored", 16'hC000, 4'b0000, 8'hFF);
  endtask

  task automatic t_disabled;
    cfg_write(6'h01, 4'b0001, 32'h0);
    probe("R7 legacy disabled", 16'h01F0, 4'b0000, 8'hFF);
    cfg_write(6'h10, 4'hF, 32'h0);
    probe("R7 native disabled", 16'hC000, 4'b0000, 8'hFF);
    cfg_write(6'h01, 4'b0001, 32'h1);
  endtask

  task automatic t_native_both;
    cfg_write(6'h10, 4'hF, 32'h0);
    probe("R5 pri cmd", 16'hC007, 4'b1000, 8'hA5);
    probe("R5 pri ctl", 16'hC012, 4'b0100, 8'hA5);
    probe("R5 pri ctl end", 16'hC014, 4'b0000, 8'hFF);
    probe("R5 sec cmd", 16'hC020, 4'b0010, 8'h5A);
    probe("R5 sec ctl", 16'hC033, 4'b0001, 8'h5A);
    probe("R5 legacy addr off", 16'h01F0, 4'b0000, 8'hFF);
  endtask

  task automatic t_steer;
    cfg_write(6'h10, 4'b0010, 32'h0000_8000);
    probe("R6 sec on BAR0", 16'hC003, 4'b0010, 8'h5A);
    probe("R6 sec on BAR1", 16'hC010, 4'b0001, 8'h5A);
    probe("R6 BAR2 silent", 16'hC020, 4'b0000, 8'hFF);
    probe("R6 BAR3 silent", 16'hC030, 4'b0000, 8'hFF);
    probe("R6 pri legacy", 16'h01F0, 4'b1000, 8'hA5);
  endtask

  task automatic t_irq;  // primary legacy, secondary native
    irq_check("R9 pri legacy irq", 1'b1, 1'b0, 3'b100);
    irq_check("R10 sec native pci", 1'b1, 1'b1, 3'b101);
    cfg_write(6'h01, 4'b0001, 32'h0);
    irq_check("R9 R10 disabled", 1'b1, 1'b1, 3'b100);
    cfg_write(6'h01, 4'b0001, 32'h1);
    cfg_write(6'h10, 4'hF, 32'h8000_0000);
    irq_check("R9 sec legacy irq", 1'b1, 1'b1, 3'b011);
    cfg_write(6'h10, 4'hF, 32'h0);
    irq_check("R10 both native", 1'b1, 1'b0, 3'b001);
    irq_check("R10 idle", 1'b0, 1'b0, 3'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bars();
    t_byte_enables();
    t_legacy();
    t_disabled();
    t_native_both();
    t_steer();
    t_irq();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule